// File: doc/BRIEF.md
# Round-Robin Ready-Warp Issue Scheduler

This block decides, at every issue opportunity, which resident warp of a streaming multiprocessor sends its next instruction to the dispatch path. A warp can be picked when its next instruction is ready and it is not waiting on a long-latency memory access. The search for a candidate begins at the warp after the last one granted and wraps around. Switching from one warp to another costs no cycles, so other ready warps fill the time that one warp spends waiting on memory.

The dispatch datapath is narrower than a warp, so each grant holds the path for a fixed number of cycles. When a granted instruction is a global memory access, the warp is held back for a programmable latency, loaded from `mem_latency` at issue time (typically 200 cycles). A per-warp completion event can end that wait early. Each grant also reports the first thread ID of the chosen warp. A warp covers a consecutive run of thread IDs.

Top module: `wis_warp_scheduler`

## Requirements
- R1: While reset is held and on the first cycle after it, `issue_valid` is 0 and every bit of `warp_stalled` is 0.
- R2: A warp is granted only if, at the edge where the decision is made, its `warp_ready` bit is 1 and its `warp_stalled` bit is 0.
- R3: The granted warp is the first eligible warp found by scanning upward from the warp after the previous grant and wrapping past the highest index. Before the first grant the scan starts at warp 0.
- R4: At any free issue opportunity where at least one warp is eligible, `issue_valid` is 1 on the next cycle. No idle cycle is inserted when switching warps.
- R5: Two `issue_valid` strobes are at least DISPATCH_CYCLES (default 4) cycles apart. With a warp eligible the whole time, they are exactly that far apart.
- R6: When no warp is eligible, `issue_valid` stays 0 and the scan start does not move.
- R7: Granting a warp whose `warp_is_mem` bit is 1 sets its `warp_stalled` bit for exactly `mem_latency` cycles, counted from the cycle in which the strobe is visible.
- R8: A pulse on `mem_done[w]` clears `warp_stalled[w]` at the next clock edge.
- R9: A memory grant with `mem_latency` equal to 0 does not stall the warp.
- R10: `issue_tid_base` equals `issue_warp` × WARP_SIZE (default 32). Warp w therefore covers thread IDs 32w to 32w+31.
- R11: A warp's stall bit rises only after that warp has received a memory grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NUM_WARPS | Per warp: next instruction is ready |
| warp_is_mem | input | NUM_WARPS | Per warp: next instruction is a global memory access |
| mem_latency | input | LAT_W | Stall length loaded on a memory grant |
| mem_done | input | NUM_WARPS | Per warp completion pulse that ends a stall early |
| issue_valid | output | 1 | Issue strobe, one cycle per grant |
| issue_warp | output | $clog2(NUM_WARPS) | Index of the granted warp |
| issue_tid_base | output | $clog2(NUM_WARPS*WARP_SIZE) | First thread ID of the granted warp |
| warp_stalled | output | NUM_WARPS | Per warp: waiting on a memory access |

## Verification
The assertions assume that `warp_ready`, `warp_is_mem`, `mem_latency` and `mem_done` are stable around each rising edge. They also assume that `mem_done` does not need to win over a memory grant to the same warp in the same cycle, because in that case the new grant takes priority. The bench changes every input only on the falling edge. It pulses `mem_done` for a single cycle at a time, and it keeps `mem_latency` constant within each phase, so the stall length a bench model predicts matches the value loaded at grant time.

// File: rtl/wis_pkg.sv
package wis_pkg;

  // next index after v in a ring of n entries
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // first thread ID covered by a warp
  function automatic int unsigned thread_base(input int unsigned warp, input int unsigned wsize);
    return warp * wsize;
  endfunction

  // ring position offset k places after start
  function automatic int unsigned ring_pos(input int unsigned start, input int unsigned k,
                                           input int unsigned n);
    int unsigned s;
    s = start + k;
    return (s >= n) ? s - n : s;
  endfunction

endpackage

// File: rtl/wis_rr_arbiter.sv
module wis_rr_arbiter #(
  parameter int unsigned NUM_WARPS = 32,
  parameter int unsigned IDX_W     = 5
) (
  input  logic [NUM_WARPS-1:0] elig_i,
  input  logic [IDX_W-1:0]     start_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     pick_o
);
  logic found;

  always_comb begin
    any_o  = |elig_i;
    pick_o = '0;
    found  = 1'b0;
    for (int unsigned k = 0; k < NUM_WARPS; k++) begin
      int unsigned j;
      j = wis_pkg::ring_pos(32'(start_i), k, NUM_WARPS);
      if (!found && elig_i[j]) begin
        pick_o = IDX_W'(j);
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/wis_stall_timer.sv
module wis_stall_timer #(
  parameter int unsigned LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LAT_W-1:0] load_val_i,
  input  logic             done_i,
  output logic             stalled_o
);
  logic [LAT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                remain_q <= '0;
    else if (load_i)           remain_q <= load_val_i;
    else if (done_i)           remain_q <= '0;
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign stalled_o = (remain_q != '0);

endmodule

// File: rtl/wis_dispatch_slot.sv
module wis_dispatch_slot #(
  parameter int unsigned DISPATCH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_i,
  output logic free_o
);
  localparam int unsigned CW = (DISPATCH_CYCLES > 1) ? $clog2(DISPATCH_CYCLES + 1) : 1;

  logic [CW-1:0] busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              busy_q <= '0;
    else if (issue_i)        busy_q <= CW'(DISPATCH_CYCLES - 1);
    else if (busy_q != '0)   busy_q <= busy_q - 1'b1;
  end

  assign free_o = (busy_q == '0);

endmodule

// File: rtl/wis_warp_scheduler.sv
module wis_warp_scheduler #(
  parameter int unsigned NUM_WARPS       = 32,
  parameter int unsigned WARP_SIZE       = 32,
  parameter int unsigned DISPATCH_CYCLES = 4,
  parameter int unsigned LAT_W           = 16,
  localparam int unsigned IDX_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int unsigned TID_W = (NUM_WARPS * WARP_SIZE > 1) ? $clog2(NUM_WARPS * WARP_SIZE) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_ready,
  input  logic [NUM_WARPS-1:0] warp_is_mem,
  input  logic [LAT_W-1:0]     mem_latency,
  input  logic [NUM_WARPS-1:0] mem_done,
  output logic                 issue_valid,
  output logic [IDX_W-1:0]     issue_warp,
  output logic [TID_W-1:0]     issue_tid_base,
  output logic [NUM_WARPS-1:0] warp_stalled
);
  // named internal events, observed by the bound checker
  logic [NUM_WARPS-1:0] eligible;
  logic [NUM_WARPS-1:0] mem_load;
  logic                 slot_free;
  logic                 any_elig;
  logic                 issue_now;
  logic [IDX_W-1:0]     pick;
  logic [IDX_W-1:0]     rr_start_q;

  assign eligible  = warp_ready & ~warp_stalled;
  assign issue_now = slot_free & any_elig;

  wis_rr_arbiter #(.NUM_WARPS(NUM_WARPS), .IDX_W(IDX_W)) u_arb (
    .elig_i  (eligible),
    .start_i (rr_start_q),
    .any_o   (any_elig),
    .pick_o  (pick)
  );

  wis_dispatch_slot #(.DISPATCH_CYCLES(DISPATCH_CYCLES)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue_i (issue_now),
    .free_o  (slot_free)
  );

  generate
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      assign mem_load[w] = issue_now && (pick == IDX_W'(w)) && warp_is_mem[w];

      wis_stall_timer #(.LAT_W(LAT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (mem_load[w]),
        .load_val_i (mem_latency),
        .done_i     (mem_done[w]),
        .stalled_o  (warp_stalled[w])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_start_q     <= '0;
      issue_valid    <= 1'b0;
      issue_warp     <= '0;
      issue_tid_base <= '0;
    end else begin
      issue_valid <= issue_now;
      if (issue_now) begin
        rr_start_q     <= IDX_W'(wis_pkg::wrap_inc(32'(pick), NUM_WARPS));
        issue_warp     <= pick;
        issue_tid_base <= TID_W'(wis_pkg::thread_base(32'(pick), WARP_SIZE));
      end
    end
  end

endmodule

// File: rtl/wis_sched_chk.sv
module wis_sched_chk #(
  parameter int unsigned NUM_WARPS       = 32,
  parameter int unsigned DISPATCH_CYCLES = 4,
  parameter int unsigned LAT_W           = 16,
  parameter int unsigned IDX_W           = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] warp_ready,
  input logic [NUM_WARPS-1:0] warp_stalled,
  input logic [LAT_W-1:0]     mem_latency,
  input logic                 issue_valid,
  input logic [IDX_W-1:0]     issue_warp,
  input logic                 slot_free,
  input logic [NUM_WARPS-1:0] mem_load
);
  localparam int unsigned GW = $clog2(DISPATCH_CYCLES + 2);

  logic [NUM_WARPS-1:0] ready_seen_q;
  logic [NUM_WARPS-1:0] stall_seen_q;
  logic [GW-1:0]        gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_seen_q <= '0;
      stall_seen_q <= '0;
      gap_q        <= GW'(DISPATCH_CYCLES);
    end else begin
      ready_seen_q <= warp_ready;
      stall_seen_q <= warp_stalled;
      if (issue_valid)                       gap_q <= GW'(1);
      else if (gap_q < GW'(DISPATCH_CYCLES)) gap_q <= gap_q + 1'b1;
    end
  end

  // R2
  eligible_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (ready_seen_q[issue_warp] && !stall_seen_q[issue_warp]));

  // R4
  zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_free && ((warp_ready & ~warp_stalled) != '0)) |=> issue_valid);

  // R5
  dispatch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (gap_q >= GW'(DISPATCH_CYCLES)));

  // R6
  no_ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warp_ready & ~warp_stalled) == '0) |=> !issue_valid);

  // R7
  mem_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_load != '0) && (mem_latency != '0)) |=>
      ((warp_stalled & $past(mem_load)) == $past(mem_load)));

  // R11
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((warp_stalled & ~$past(warp_stalled) & ~$past(mem_load)) == '0));

endmodule

bind wis_warp_scheduler wis_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .DISPATCH_CYCLES(DISPATCH_CYCLES), .LAT_W(LAT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_stalled(warp_stalled),
  .mem_latency(mem_latency), .issue_valid(issue_valid), .issue_warp(issue_warp),
  .slot_free(slot_free), .mem_load(mem_load)
);

// File: tb/tb_wis_warp_scheduler.sv
`timescale 1ns/1ps
module tb_wis_warp_scheduler;
  localparam int NW = 8;
  localparam int WS = 32;
  localparam int DC = 4;
  localparam int LW = 16;
  localparam int IW = 3;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] warp_ready = '0;
  logic [NW-1:0] warp_is_mem = '0;
  logic [LW-1:0] mem_latency = 16'd200;
  logic [NW-1:0] mem_done = '0;
  logic          issue_valid;
  logic [IW-1:0] issue_warp;
  logic [TW-1:0] issue_tid_base;
  logic [NW-1:0] warp_stalled;

  always #2.5 clk = ~clk;

  wis_warp_scheduler #(.NUM_WARPS(NW), .WARP_SIZE(WS), .DISPATCH_CYCLES(DC), .LAT_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready), .warp_is_mem(warp_is_mem),
    .mem_latency(mem_latency), .mem_done(mem_done), .issue_valid(issue_valid),
    .issue_warp(issue_warp), .issue_tid_base(issue_tid_base), .warp_stalled(warp_stalled)
  );

  int checks = 0;
  int fails  = 0;

  // reference model, stepped at the rising edge from bench-driven inputs only
  int m_cnt [NW];
  int m_start, m_busy, m_warp;
  bit m_valid;
  bit [NW-1:0] m_prev_elig;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_start = 0; m_busy = 0; m_warp = 0; m_valid = 0; m_prev_elig = '0;
    end else begin
      bit [NW-1:0] el;
      int g;
      bit go;
      for (int i = 0; i < NW; i++) el[i] = warp_ready[i] && (m_cnt[i] == 0);
      m_prev_elig = el;
      go = (m_busy == 0) && (el != '0);
      g = -1;
      if (go)
        for (int k = 0; k < NW; k++)
          if (g < 0 && el[(m_start + k) % NW]) g = (m_start + k) % NW;
      for (int i = 0; i < NW; i++) begin
        if (go && i == g && warp_is_mem[i]) m_cnt[i] = int'(mem_latency);
        else if (mem_done[i])               m_cnt[i] = 0;
        else if (m_cnt[i] != 0)             m_cnt[i] = m_cnt[i] - 1;
      end
      m_valid = go;
      if (go) begin
        m_warp = g; m_start = (g + 1) % NW; m_busy = DC - 1;
      end else if (m_busy != 0) m_busy = m_busy - 1;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  int since_last = 1000;
  int stb_cnt = 0;
  int stall_cyc [NW];

  // one cycle: wait for the falling edge, then compare against the model
  task automatic tick();
    @(negedge clk);
    check("R4 strobe", issue_valid, m_valid);
    check("R7 stall vector", warp_stalled, m_stall_vec());
    if (issue_valid) begin
      check("R3 granted warp", issue_warp, m_warp);
      check("R10 thread base", issue_tid_base, m_warp * WS);
      check("R2 grant eligible", m_prev_elig[issue_warp], 1);
      if (since_last < DC) check("R5 spacing", since_last, DC);
      since_last = 1;
      stb_cnt++;
    end else since_last++;
    for (int i = 0; i < NW; i++) if (warp_stalled[i]) stall_cyc[i]++;
  endtask

  function automatic bit [NW-1:0] m_stall_vec();
    bit [NW-1:0] v;
    for (int i = 0; i < NW; i++) v[i] = (m_cnt[i] != 0);
    return v;
  endfunction

  task automatic clear_counts();
    stb_cnt = 0;
    foreach (stall_cyc[i]) stall_cyc[i] = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] lfsr;
    int waitc;
    repeat (3) @(negedge clk);
    check("R1 strobe in reset", issue_valid, 0);
    check("R1 stall in reset", warp_stalled, 0);
    rst_n = 1'b1;
    tick();
    check("R1 strobe after reset", issue_valid, 0);
    check("R1 stall after reset", warp_stalled, 0);

    // all ready, no memory: grants 0..7 in order every DC cycles
    clear_counts();
    warp_ready = '1; warp_is_mem = '0;
    repeat (40) tick();
    check("R5 strobes in 40 cycles", stb_cnt, 40 / DC);
    check("R11 no stall without memory grant", stall_cyc[0] + stall_cyc[5], 0);

    // nothing ready: no strobe, scan start kept
    warp_ready = '0;
    clear_counts();
    repeat (20) tick();
    check("R6 no strobe when idle", stb_cnt, 0);
    warp_ready = 8'b0010_0100;
    repeat (8) tick();

    // memory grant with latency 200 on warp 3
    warp_ready = '0; repeat (6) tick();
    clear_counts();
    mem_latency = 16'd200;
    warp_ready = 8'b0000_1000; warp_is_mem = 8'b0000_1000;
    waitc = 0;
    do begin tick(); waitc++; end while (!issue_valid && waitc < 20);
    warp_ready = '0; warp_is_mem = '0;
    repeat (230) tick();
    check("R7 stall length 200", stall_cyc[3], 200);

    // latency zero: no stall, back-to-back grants
    clear_counts();
    mem_latency = 16'd0;
    warp_ready = 8'b0001_0000; warp_is_mem = 8'b0001_0000;
    repeat (20) tick();
    check("R9 no stall at zero latency", stall_cyc[4], 0);
    check("R9 strobes at zero latency", stb_cnt, 5);
    warp_ready = '0; warp_is_mem = '0;
    repeat (6) tick();

    // completion event ends the stall early
    mem_latency = 16'd100;
    warp_ready = 8'b0000_0010; warp_is_mem = 8'b0000_0010;
    waitc = 0;
    do begin tick(); waitc++; end while (!issue_valid && waitc < 20);
    warp_ready = '0; warp_is_mem = '0;
    repeat (10) tick();
    check("R8 stalled before completion", warp_stalled[1], 1);
    mem_done = 8'b0000_0010;
    tick();
    mem_done = '0;
    check("R8 cleared by completion", warp_stalled[1], 0);
    repeat (6) tick();

    // exhaustive ready masks, one opportunity each
    for (int m = 0; m < 256; m++) begin
      warp_ready = 8'(m);
      repeat (DC) tick();
    end

    // pseudo-random mix of readiness, memory grants and completions
    lfsr = 16'hACE1;
    for (int c = 0; c < 4000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      warp_ready  = lfsr[7:0] | lfsr[15:8];
      warp_is_mem = lfsr[11:4];
      mem_latency = 16'(5 + (c % 17));
      mem_done    = (lfsr[2:0] == 3'd5) ? (8'd1 << lfsr[5:3]) : '0;
      tick();
    end
    mem_done = '0; warp_ready = '0;
    repeat (40) tick();
    report();
  end
endmodule